// File: doc/BRIEF.md
# Phased lock-and-store register

This block is a bank of single-bit storage cells that share one lock control. Nothing is captured by a plain write enable. A small sequencer runs each command through three one-clock phases: it opens the shared lock, lets each cell act, then closes the lock again. While the lock is closed, the data inputs can change freely and the stored word does not move.

Each cell holds a flag that records whether its state element has been moved away from rest. During a store, a cell moves only when its data input is 0. A data input of 1 holds the cell at rest. The output is the inverse of that flag, so a moved cell reads 0 and a resting cell reads 1. An erased bank therefore reads all ones.

A store can only move a cell away from rest and can never bring it back. For that reason an erase command is needed before new data can be written. The sequencer flags a store that is issued without an erase since the previous store, and it also flags malformed or mistimed commands.

Top module: `lock_store_bank`

## Requirements
- R1: While rst_ni is low and after its release, every bit of q_o reads 1, and latch_o, busy_o, done_o and err_o read 0.
- R2: A command accepted while idle makes busy_o high for exactly three cycles, beginning at the first clock edge after the command is sampled. done_o is high only in the third of those cycles.
- R3: latch_o is high in the first and second busy cycles and low in the third busy cycle and whenever idle.
- R4: A store issued after reset or after an erase leaves each bit of q_o equal to the data_i bit sampled at the edge that ends the second busy cycle: a data bit of 0 reads 0 and a data bit of 1 reads 1. No error is flagged.
- R5: q_o changes only at the edge that ends the second busy cycle. Changes on data_i at any other time have no effect on q_o.
- R6: An erase command (erase_i=1, store_i=0, accepted while idle) leaves every bit of q_o at 1 at the end of the third busy cycle.
- R7: A store issued while an earlier store has not been followed by an erase leaves bits that read 0 at 0, sets bits whose data is 0 to 0, and still runs its three phases. err_o pulses high for one cycle, in the first busy cycle.
- R8: A store or erase raised while busy is ignored. The running command finishes unchanged, and err_o pulses high for one cycle after the edge that sampled the stray command.
- R9: store_i and erase_i high together while idle start nothing: busy_o stays 0, q_o is unchanged, and err_o pulses high for one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| store_i | input | 1 | Store command request |
| erase_i | input | 1 | Erase command request |
| data_i | input | WIDTH | Per-bit data inputs |
| q_o | output | WIDTH | Stored word (moved cell reads 0) |
| latch_o | output | 1 | Shared lock open |
| busy_o | output | 1 | Command phases in progress |
| done_o | output | 1 | Last (relock) phase |
| err_o | output | 1 | One-cycle illegal command flag |

## Verification
The hardest situation to create from the ports is a command that arrives in the middle of a running sequence. The stray request must land exactly in the first busy cycle, after the real command has been accepted but before the cells act. The bench drives the real store, waits for the accepting edge, and then raises erase for exactly one cycle. It checks that the error pulse appears, that the cells still capture the store data rather than being cleared, and that the phase timing is unchanged. The cumulative effect of two stores without an erase between them is also reached only through a planned command order.

// File: rtl/lock_store_bank_pkg.sv
package lock_store_bank_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_UNLOCK = 2'd1,
    PH_ACT    = 2'd2,
    PH_RELOCK = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_STORE = 2'd1,
    OP_ERASE = 2'd2
  } op_e;
endpackage

// File: rtl/lsb_cell.sv
module lsb_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latch_open_i,
  input  logic move_i,
  input  logic clear_i,
  input  logic d_i,
  output logic q_o
);
  logic moved_q;

  // state element may only change while the shared lock is open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      moved_q <= 1'b0;
    end else if (latch_open_i) begin
      if (clear_i)            moved_q <= 1'b0;
      else if (move_i && !d_i) moved_q <= 1'b1;
    end
  end

  assign q_o = ~moved_q;
endmodule

// File: rtl/lsb_seq.sv
module lsb_seq
  import lock_store_bank_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic store_i,
  input  logic erase_i,
  output logic latch_open_o,
  output logic act_store_o,
  output logic act_erase_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  phase_e ph_q, ph_d;
  op_e    op_q, op_d;
  logic   written_q, written_d;
  logic   err_q, err_d;
  logic   idle, acc_store, acc_erase, conflict, stray;

  assign idle      = (ph_q == PH_IDLE);
  assign acc_store = idle && store_i && !erase_i;
  assign acc_erase = idle && erase_i && !store_i;
  assign conflict  = idle && store_i && erase_i;
  assign stray     = !idle && (store_i || erase_i);

  always_comb begin
    ph_d      = ph_q;
    op_d      = op_q;
    written_d = written_q;
    err_d     = conflict || stray || (acc_store && written_q);
    unique case (ph_q)
      PH_IDLE: begin
        if (acc_store) begin
          ph_d      = PH_UNLOCK;
          op_d      = OP_STORE;
          written_d = 1'b1;
        end else if (acc_erase) begin
          ph_d      = PH_UNLOCK;
          op_d      = OP_ERASE;
          written_d = 1'b0;
        end
      end
      PH_UNLOCK: ph_d = PH_ACT;
      PH_ACT:    ph_d = PH_RELOCK;
      PH_RELOCK: begin
        ph_d = PH_IDLE;
        op_d = OP_NONE;
      end
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      op_q      <= OP_NONE;
      written_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      op_q      <= op_d;
      written_q <= written_d;
      err_q     <= err_d;
    end
  end

  assign latch_open_o = (ph_q == PH_UNLOCK) || (ph_q == PH_ACT);
  assign act_store_o  = (ph_q == PH_ACT) && (op_q == OP_STORE);
  assign act_erase_o  = (ph_q == PH_ACT) && (op_q == OP_ERASE);
  assign busy_o       = !idle;
  assign done_o       = (ph_q == PH_RELOCK);
  assign err_o        = err_q;
endmodule

// File: rtl/lock_store_bank.sv
module lock_store_bank #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             store_i,
  input  logic             erase_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o,
  output logic             latch_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  logic latch_open, act_store, act_erase;

  lsb_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .store_i      (store_i),
    .erase_i      (erase_i),
    .latch_open_o (latch_open),
    .act_store_o  (act_store),
    .act_erase_o  (act_erase),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    lsb_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .latch_open_i (latch_open),
      .move_i       (act_store),
      .clear_i      (act_erase),
      .d_i          (data_i[i]),
      .q_o          (q_o[i])
    );
  end

  assign latch_o = latch_open;
endmodule

// File: rtl/lock_store_bank_chk.sv
module lock_store_bank_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] q_o,
  input logic             latch_o,
  input logic             busy_o,
  input logic             done_o
);
  p_done_relock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && !latch_o));

  p_done_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  p_latch_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> busy_o);

  p_latch_two_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> latch_o);

  p_q_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_o) |-> done_o);
endmodule

bind lock_store_bank lock_store_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .q_o     (q_o),
  .latch_o (latch_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/lock_store_bank_bench.sv
`timescale 1ns/1ps
module lock_store_bank_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         store = 1'b0, erase = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] q;
  logic         latch, busy, done, err;
  int           total = 0, bad = 0;
  bit           finished = 0;

  always #2 clk = ~clk;

  lock_store_bank #(.WIDTH(W)) u_lock_store_bank (
    .clk_i(clk), .rst_ni(rst_n), .store_i(store), .erase_i(erase),
    .data_i(data), .q_o(q), .latch_o(latch), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ctl(input string req, input logic b, input logic l, input logic d, input logic e);
    check({req, " busy"}, busy, b);
    check({req, " latch"}, latch, l);
    check({req, " done"}, done, d);
    check({req, " err"}, err, e);
  endtask

  // full command: drive at negedge, check each phase at following negedges
  task automatic run_cmd(input logic st, input logic er, input logic [W-1:0] d,
                         input logic exp_err, input logic [W-1:0] exp_q, input string req);
    logic [W-1:0] old_q;
    old_q = q;
    @(negedge clk); store = st; erase = er; data = d;
    @(negedge clk); store = 0; erase = 0;
    chk_ctl({req, " R2 R3 ph1"}, 1, 1, 0, exp_err);
    check({req, " R5 ph1 q"}, q, old_q);
    @(negedge clk);
    chk_ctl({req, " R2 R3 ph2"}, 1, 1, 0, 0);
    check({req, " R5 ph2 q"}, q, old_q);
    @(negedge clk);
    chk_ctl({req, " R2 R3 ph3"}, 1, 0, 1, 0);
    check({req, " q"}, q, exp_q);
    @(negedge clk);
    chk_ctl({req, " R2 idle"}, 0, 0, 0, 0);
    check({req, " q hold"}, q, exp_q);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 q in reset", q, 4'hF);
    chk_ctl("R1 in reset", 0, 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 q after release", q, 4'hF);
    chk_ctl("R1 after release", 0, 0, 0, 0);
  endtask

  task automatic t_first_store;
    run_cmd(1, 0, 4'b1010, 0, 4'b1010, "R4 first store");
  endtask

  task automatic t_data_wiggle;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); data = W'(i * 3);
      @(negedge clk);
      check("R5 idle data change", q, 4'b1010);
    end
  endtask

  task automatic t_restore;
    run_cmd(1, 0, 4'b0101, 1, 4'b0000, "R7 store without erase");
  endtask

  task automatic t_erase;
    run_cmd(0, 1, 4'b0000, 0, 4'b1111, "R6 erase");
    run_cmd(1, 0, 4'b0110, 0, 4'b0110, "R4 store after erase");
    run_cmd(0, 1, 4'b0011, 0, 4'b1111, "R6 erase again");
  endtask

  task automatic t_busy_cmd;
    @(negedge clk); store = 1; data = 4'b1100;
    @(negedge clk); store = 0; erase = 1;      // stray erase in first busy cycle
    chk_ctl("R8 ph1", 1, 1, 0, 0);
    @(negedge clk); erase = 0;
    chk_ctl("R8 ph2 err", 1, 1, 0, 1);
    @(negedge clk);
    chk_ctl("R8 ph3", 1, 0, 1, 0);
    check("R8 store kept", q, 4'b1100);
    @(negedge clk);
    chk_ctl("R8 idle", 0, 0, 0, 0);
    check("R8 q hold", q, 4'b1100);
  endtask

  task automatic t_conflict;
    @(negedge clk); store = 1; erase = 1; data = 4'b0000;
    @(negedge clk); store = 0; erase = 0;
    chk_ctl("R9 conflict", 0, 0, 0, 1);
    check("R9 q unchanged", q, 4'b1100);
    @(negedge clk);
    chk_ctl("R9 after", 0, 0, 0, 0);
    check("R9 q still", q, 4'b1100);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_first_store();
    t_data_wiggle();
    t_restore();
    t_erase();
    t_busy_cmd();
    t_conflict();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule